// File: doc/BRIEF.md
# Debug Module Register File

This block is the register file that an external debug transport talks to in a small multi-hart system. The transport issues 32-bit reads and writes on a simple request port: a valid strobe, a write flag, a word address and write data. One cycle later the block answers with a single-cycle response pulse that carries the read data and an error flag. The file holds a control word, eight general data words, eight program-buffer words, a read-only abstract-command status word and a read-only access-capability word.

The control word drives a halt-request line toward each hart. It selects one hart through a hart-select field. A read of the control word reports the status of the selected hart live, from that hart's `hart_halted` and `hart_exists` inputs. The control logic is a two-state machine. DM_INACTIVE is entered on reset and on a control write whose active bit is 0 (transition DEACTIVATE). DM_ACTIVE is entered on a control write whose active bit is 1 (transition ACTIVATE). Writes with active = 1 made while already active stay in DM_ACTIVE (transition UPDATE). The response channel is a three-state machine. RSP_IDLE means no pulse. RSP_OK is entered after a request that decodes. RSP_FAIL is entered after a request that does not decode or that is rejected. Each of the two answer states lasts exactly one cycle and falls back to RSP_IDLE unless another request follows.

Address map (word addresses, 7 bits): data words 0x04–0x0B, control 0x10, abstract status 0x11, access capability 0x12, program buffer 0x20–0x27. Control word fields: [0] active, [1] hart reset, [2] halt request, [13:4] hart select, [17:16] hart status, [18] authenticated, [19] auth busy, [21:20] auth type, [27:24] version. All other bits read 0.

Top module: `dbg_regfile`

## Requirements
- R1: Eight 32-bit data words at addresses 0x04 to 0x0B are readable and writable independently, and each reads 0 after the synchronous active-low reset.
- R2: Eight 32-bit program-buffer words at addresses 0x20 to 0x27 are readable and writable independently of the data words, and each reads 0 after reset.
- R3: A control write (address 0x10) with bit 0 = 1 stores the hart-reset bit [1], the halt-request bit [2] and hart-select [13:4], and bit 0 then reads back 1.
- R4: A control write with bit 0 = 0, and also the reset, returns the control word to its reset reading: active 0, hart reset 0, halt request 0, hart select 0, authenticated [18] = 1, auth busy 0, auth type [21:20] = 0, version [27:24] = 1. All `halt_req` outputs are cleared, whatever the other bits of the written value.
- R5: Hart status [17:16] reads 3 when hart-select is not below the hart count or that hart's `hart_exists` is 0. Otherwise it reads 0 when `hart_halted` of the selected hart is 1 and 1 when it is 0. The value 2 is never produced.
- R6: Control bit [2] reads the current `halt_req` output of the selected hart. When the selection is out of range, it reads the stored halt-request bit.
- R7: After a control write with bit 0 = 1, `halt_req` of the newly selected hart equals the written bit [2]. Every other hart's `halt_req` keeps its value, and `halt_req` changes only on control writes and reset.
- R8: Reading 0x11 returns the data-word count (8) in bits [3:0]. Reading 0x12 returns the program-buffer word count (8) in bits [4:0]. All other bits are 0.
- R9: A write to 0x11 is a command request that is always rejected with an error response and no state change. A write to 0x12 is also answered with an error and has no effect.
- R10: A read of any address outside the map answers with the error flag set and read data 0. A write to such an address answers with an error and changes no stored word.
- R11: Every request receives exactly one response pulse in the following cycle, and no pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (7) | Word address |
| req_wdata | input | 32 | Write data |
| hart_halted | input | NUM_HARTS (4) | Per-hart halted indication |
| hart_exists | input | NUM_HARTS (4) | Per-hart presence indication |
| halt_req | output | NUM_HARTS (4) | Per-hart halt request |
| rsp_valid | output | 1 | Response pulse, one cycle after each request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 32 | Response read data, 0 on writes and errors |

## Verification
Two functions can meet in one control write: the deactivation that clears every hart's halt request, and the latching of the halt-request bit for the hart named in that same written value. The bench first raises halt requests on several harts. It then issues a control write with active 0 but halt request 1 and a valid hart select. It judges that all `halt_req` lines drop and that the next control read equals the reset reading. A second overlap is a live status read while the hart inputs change. The bench sweeps hart select across in-range and out-of-range values under two halted patterns and compares every control read with a word it assembles arithmetically from its own model.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    localparam int DW        = 32;
    localparam int SEL_W     = 10;

    // control word field positions
    localparam int CTL_ACT      = 0;
    localparam int CTL_HRESET   = 1;
    localparam int CTL_HALT     = 2;
    localparam int CTL_SEL_LO   = 4;
    localparam int CTL_STAT_LO  = 16;
    localparam int CTL_AUTH     = 18;
    localparam int CTL_ABUSY    = 19;
    localparam int CTL_ATYPE_LO = 20;
    localparam int CTL_VER_LO   = 24;

    localparam logic [1:0] AUTH_NONE   = 2'd0;
    localparam logic [3:0] CTL_VERSION = 4'd1;

    typedef enum logic [1:0] {
        HS_HALTED  = 2'd0,
        HS_RUNNING = 2'd1,
        HS_UNAVAIL = 2'd2,
        HS_ABSENT  = 2'd3
    } hart_stat_e;

    typedef enum logic {
        DM_INACTIVE = 1'b0,
        DM_ACTIVE   = 1'b1
    } dm_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_OK   = 2'd1,
        RSP_FAIL = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/dbg_word_bank.sv
module dbg_word_bank
    import dbgreg_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int ADDR_W = 7,
    parameter int BASE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              hit,
    output logic [DW-1:0]     rdata
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [WORDS-1:0][DW-1:0] words;
    logic [ADDR_W-1:0]        off;
    logic [IDX_W-1:0]         idx;
    logic                     wr_hit;

    always_comb begin
        off    = req_addr - ADDR_W'(BASE);
        hit    = (req_addr >= ADDR_W'(BASE)) && (off < ADDR_W'(WORDS));
        idx    = off[IDX_W-1:0];
        wr_hit = req_valid && req_write && hit;
        rdata  = hit ? words[idx] : '0;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (wr_hit && (idx == IDX_W'(g)))
                words[g] <= req_wdata;
        end
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(words)); // R10

endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
    import dbgreg_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_act,
    input  logic                 wr_hreset,
    input  logic                 wr_halt,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_exists,
    output logic [DW-1:0]        ctl_rdata,
    output logic [NUM_HARTS-1:0] halt_req
);

    localparam int HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    dm_state_e        dm_state, dm_next;
    logic             hreq_q;
    logic             hrst_q;
    logic [SEL_W-1:0] sel_q;
    logic             sel_ok;
    logic [HIDX_W-1:0] sel_idx;
    logic             sel_halt;
    hart_stat_e       stat;

    // next-state: ACTIVATE, UPDATE, DEACTIVATE
    always_comb begin
        dm_next = dm_state;
        unique case (dm_state)
            DM_INACTIVE: if (wr_en && wr_act)  dm_next = DM_ACTIVE;
            DM_ACTIVE:   if (wr_en && !wr_act) dm_next = DM_INACTIVE;
            default:     dm_next = DM_INACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dm_state <= DM_INACTIVE;
        else
            dm_state <= dm_next;
    end

    // stored fields and per-hart halt requests
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_en && !wr_act)) begin
            hreq_q   <= 1'b0;
            hrst_q   <= 1'b0;
            sel_q    <= '0;
            halt_req <= '0;
        end else if (wr_en) begin
            hreq_q <= wr_halt;
            hrst_q <= wr_hreset;
            sel_q  <= wr_sel;
            for (int i = 0; i < NUM_HARTS; i++) begin
                if (wr_sel == SEL_W'(i))
                    halt_req[i] <= wr_halt;
            end
        end
    end

    // live readback of the selected hart
    always_comb begin
        sel_ok   = sel_q < SEL_W'(NUM_HARTS);
        sel_idx  = sel_q[HIDX_W-1:0];
        sel_halt = sel_ok ? halt_req[sel_idx] : hreq_q;
        if (!sel_ok || !hart_exists[sel_idx])
            stat = HS_ABSENT;
        else if (hart_halted[sel_idx])
            stat = HS_HALTED;
        else
            stat = HS_RUNNING;

        ctl_rdata                         = '0;
        ctl_rdata[CTL_ACT]                = (dm_state == DM_ACTIVE);
        ctl_rdata[CTL_HRESET]             = hrst_q;
        ctl_rdata[CTL_HALT]               = sel_halt;
        ctl_rdata[CTL_SEL_LO +: SEL_W]    = sel_q;
        ctl_rdata[CTL_STAT_LO +: 2]       = stat;
        ctl_rdata[CTL_AUTH]               = 1'b1;
        ctl_rdata[CTL_ABUSY]              = 1'b0;
        ctl_rdata[CTL_ATYPE_LO +: 2]      = AUTH_NONE;
        ctl_rdata[CTL_VER_LO +: 4]        = CTL_VERSION;
    end

    AST_INACTIVE_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_state == DM_INACTIVE) |-> (halt_req == '0)); // R4

    AST_DEACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_act) |=> (halt_req == '0 && sel_q == '0 && !hreq_q && !hrst_q)); // R4

    AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_act) |=> (sel_halt == $past(wr_halt))); // R7

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(halt_req)); // R7

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok) |-> (ctl_rdata[CTL_STAT_LO +: 2] == HS_ABSENT)); // R5

endmodule

// File: rtl/dbg_resp.sv
module dbg_resp
    import dbgreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          fail,
    input  logic [DW-1:0] rdata_in,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata
);

    rsp_state_e    st, st_next;
    logic [DW-1:0] data_q;

    always_comb begin
        if (!req_valid)
            st_next = RSP_IDLE;
        else if (fail)
            st_next = RSP_FAIL;
        else
            st_next = RSP_OK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RSP_IDLE;
            data_q <= '0;
        end else begin
            st     <= st_next;
            data_q <= (req_valid && !fail) ? rdata_in : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (st)
            RSP_IDLE: ;
            RSP_OK: begin
                rsp_valid = 1'b1;
                rsp_rdata = data_q;
            end
            RSP_FAIL: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R11

    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R11

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0)); // R10

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbgreg_pkg::*;
#(
    parameter int NUM_HARTS  = 4,
    parameter int DATA_WORDS = 8,
    parameter int PROG_WORDS = 8,
    parameter int ADDR_W     = 7,
    parameter int DATA_BASE  = 4,
    parameter int PROG_BASE  = 32,
    parameter int CTL_ADDR   = 16,
    parameter int ASTAT_ADDR = 17,
    parameter int ACAP_ADDR  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic [NUM_HARTS-1:0] hart_exists,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata
);

    localparam logic [DW-1:0] ASTAT_WORD = DW'(DATA_WORDS) & DW'(32'hF);
    localparam logic [DW-1:0] ACAP_WORD  = DW'(PROG_WORDS) & DW'(32'h1F);

    logic          hit_data, hit_prog, hit_ctl, hit_astat, hit_acap;
    logic          any_hit, fail, ctl_wr;
    logic [DW-1:0] data_rd, prog_rd, ctl_rd, rd_mux;

    dbg_word_bank #(.WORDS(DATA_WORDS), .ADDR_W(ADDR_W), .BASE(DATA_BASE)) u_data (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .hit(hit_data), .rdata(data_rd)
    );

    dbg_word_bank #(.WORDS(PROG_WORDS), .ADDR_W(ADDR_W), .BASE(PROG_BASE)) u_prog (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .hit(hit_prog), .rdata(prog_rd)
    );

    always_comb begin
        hit_ctl   = (req_addr == ADDR_W'(CTL_ADDR));
        hit_astat = (req_addr == ADDR_W'(ASTAT_ADDR));
        hit_acap  = (req_addr == ADDR_W'(ACAP_ADDR));
        any_hit   = hit_data || hit_prog || hit_ctl || hit_astat || hit_acap;
        // status and capability words are read-only; a status write is a rejected command
        fail      = req_write ? !(hit_data || hit_prog || hit_ctl) : !any_hit;
        ctl_wr    = req_valid && req_write && hit_ctl;
        rd_mux    = '0;
        if (!req_write)
            rd_mux = data_rd | prog_rd
                   | (hit_ctl   ? ctl_rd     : '0)
                   | (hit_astat ? ASTAT_WORD : '0)
                   | (hit_acap  ? ACAP_WORD  : '0);
    end

    dbg_ctrl #(.NUM_HARTS(NUM_HARTS)) u_ctrl (
        .clk, .rst_n,
        .wr_en    (ctl_wr),
        .wr_act   (req_wdata[CTL_ACT]),
        .wr_hreset(req_wdata[CTL_HRESET]),
        .wr_halt  (req_wdata[CTL_HALT]),
        .wr_sel   (req_wdata[CTL_SEL_LO +: SEL_W]),
        .hart_halted, .hart_exists,
        .ctl_rdata(ctl_rd),
        .halt_req
    );

    dbg_resp u_resp (
        .clk, .rst_n, .req_valid,
        .fail, .rdata_in(rd_mux),
        .rsp_valid, .rsp_err, .rsp_rdata
    );

    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !any_hit) |=> rsp_err); // R10

    AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && hit_astat) |=> (rsp_err && $stable(halt_req))); // R9

endmodule

// File: tb/sim_dbg_regfile.sv
`timescale 1ns/1ps
module sim_dbg_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  hart_halted, hart_exists;
    logic [3:0]  halt_req;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    // bench model of the control state
    logic       m_act, m_rst, m_hreq;
    int         m_sel;
    logic [3:0] m_halt;

    always #2 clk = ~clk;

    dbg_regfile u0 (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .hart_halted, .hart_exists, .halt_req,
        .rsp_valid, .rsp_err, .rsp_rdata
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        output logic v, output logic e, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        v = rsp_valid; e = rsp_err; r = rsp_rdata;
    endtask

    function automatic logic [31:0] exp_ctl();
        logic [1:0] st;
        logic       h;
        if (m_sel >= 4 || !hart_exists[m_sel]) st = 2'd3;
        else if (hart_halted[m_sel])           st = 2'd0;
        else                                   st = 2'd1;
        h = (m_sel < 4) ? m_halt[m_sel] : m_hreq;
        return 32'(m_act) | (32'(m_rst) << 1) | (32'(h) << 2) | (32'(m_sel) << 4)
             | (32'(st) << 16) | (32'd1 << 18) | (32'd1 << 24);
    endfunction

    function automatic void model_clear();
        m_act = 0; m_rst = 0; m_hreq = 0; m_sel = 0; m_halt = '0;
    endfunction

    task automatic ctl_wr(input logic act, input logic rs, input logic h, input int sel);
        logic v, e; logic [31:0] r;
        xfer(1'b1, 7'h10, 32'(act) | (32'(rs) << 1) | (32'(h) << 2) | (32'(sel & 10'h3FF) << 4), v, e, r);
        chk("R11 ctl write pulse", {31'd0, v}, 32'd1);
        if (act) begin
            m_act = 1; m_rst = rs; m_hreq = h; m_sel = sel;
            if (sel < 4) m_halt[sel] = h;
        end else begin
            model_clear();
        end
    endtask

    task automatic ctl_rd_chk(input string req);
        logic v, e; logic [31:0] r;
        xfer(1'b0, 7'h10, 32'd0, v, e, r);
        chk(req, r, exp_ctl());
    endtask

    function automatic logic mapped_rd(input int a);
        return (a >= 4 && a < 12) || (a >= 16 && a <= 18) || (a >= 32 && a < 40);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic v, e; logic [31:0] r;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        hart_exists = 4'b1011; hart_halted = 4'b0101;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R4 reset halt_req", {28'd0, halt_req}, 32'd0);
        chk("R11 no pulse after reset", {31'd0, rsp_valid}, 32'd0);
        ctl_rd_chk("R4 reset ctrl word");
        chk("R4 reset ctrl literal", exp_ctl(), 32'h0104_0000);

        // data and program words: reset value, write, readback
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, 7'(4 + i), 32'd0, v, e, r);  chk("R1 data reset", r, 32'd0);
            xfer(1'b0, 7'(32 + i), 32'd0, v, e, r); chk("R2 prog reset", r, 32'd0);
        end
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 7'(4 + i), 32'h1357_0000 + 32'(i) * 32'h0101_0101, v, e, r);
            chk("R1 data write ok", {31'd0, e}, 32'd0);
            xfer(1'b1, 7'(32 + i), ~(32'(i) * 32'h0011_2233), v, e, r);
            chk("R2 prog write ok", {31'd0, e}, 32'd0);
        end
        for (int i = 0; i < 8; i++) begin
            xfer(1'b0, 7'(4 + i), 32'd0, v, e, r);
            chk("R1 data readback", r, 32'h1357_0000 + 32'(i) * 32'h0101_0101);
            xfer(1'b0, 7'(32 + i), 32'd0, v, e, r);
            chk("R2 prog readback", r, ~(32'(i) * 32'h0011_2233));
        end

        // read-only capability words
        xfer(1'b0, 7'h11, 32'd0, v, e, r); chk("R8 status word", r, 32'd8);
        xfer(1'b0, 7'h12, 32'd0, v, e, r); chk("R8 capability word", r, 32'd8);

        // rejected command and read-only write
        xfer(1'b1, 7'h11, 32'hFFFF_FFFF, v, e, r);
        chk("R9 command rejected", {30'd0, v, e}, 32'd3);
        xfer(1'b1, 7'h12, 32'hFFFF_FFFF, v, e, r);
        chk("R9 capability write error", {30'd0, v, e}, 32'd3);
        xfer(1'b0, 7'h12, 32'd0, v, e, r); chk("R9 capability unchanged", r, 32'd8);
        chk("R9 no halt change", {28'd0, halt_req}, 32'd0);
        ctl_rd_chk("R9 ctrl unchanged");

        // hart select / halt request sweep under two halted patterns
        for (int p = 0; p < 2; p++) begin
            hart_halted = (p == 0) ? 4'b0101 : 4'b1010;
            for (int sel = 0; sel < 6; sel++) begin
                for (int h = 0; h < 2; h++) begin
                    ctl_wr(1'b1, 1'(sel + h), 1'(h), sel);
                    chk("R7 halt_req outputs", {28'd0, halt_req}, {28'd0, m_halt});
                    ctl_rd_chk("R3 R5 R6 ctrl readback");
                end
            end
        end
        ctl_wr(1'b1, 1'b0, 1'b1, 1023);
        ctl_rd_chk("R5 R6 far selection");
        hart_halted = 4'b1111;
        ctl_wr(1'b1, 1'b0, 1'b1, 2);
        ctl_rd_chk("R5 running hart");

        // deactivation coincident with a halt-request bit
        ctl_wr(1'b1, 1'b0, 1'b1, 0);
        ctl_wr(1'b1, 1'b0, 1'b1, 1);
        ctl_wr(1'b1, 1'b1, 1'b1, 3);
        chk("R7 several halts", {28'd0, halt_req}, {28'd0, m_halt});
        ctl_wr(1'b0, 1'b1, 1'b1, 2);
        chk("R4 deactivate clears all", {28'd0, halt_req}, 32'd0);
        ctl_rd_chk("R4 deactivated ctrl word");

        // full address sweep for decode errors
        for (int a = 0; a < 128; a++) begin
            xfer(1'b0, 7'(a), 32'd0, v, e, r);
            chk("R11 read pulse", {31'd0, v}, 32'd1);
            chk("R10 decode error", {31'd0, e}, {31'd0, !mapped_rd(a)});
            if (!mapped_rd(a)) chk("R10 error data zero", r, 32'd0);
        end
        for (int a = 12; a < 16; a++) begin
            xfer(1'b1, 7'(a), 32'hFFFF_FFFF, v, e, r);
            chk("R10 unmapped write error", {31'd0, e}, 32'd1);
        end
        xfer(1'b1, 7'h28, 32'hFFFF_FFFF, v, e, r);
        xfer(1'b0, 7'h0B, 32'd0, v, e, r);
        chk("R10 data untouched", r, 32'h1357_0000 + 32'd7 * 32'h0101_0101);
        xfer(1'b0, 7'h27, 32'd0, v, e, r);
        chk("R10 prog untouched", r, ~(32'd7 * 32'h0011_2233));

        @(negedge clk);
        chk("R11 idle no pulse", {31'd0, rsp_valid}, 32'd0);

        // synchronous reset mid-run
        ctl_wr(1'b1, 1'b0, 1'b1, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_clear();
        chk("R4 reset clears halt", {28'd0, halt_req}, 32'd0);
        xfer(1'b0, 7'h04, 32'd0, v, e, r); chk("R1 reset clears data", r, 32'd0);
        xfer(1'b0, 7'h20, 32'd0, v, e, r); chk("R2 reset clears prog", r, 32'd0);
        ctl_rd_chk("R4 ctrl after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule